// File: doc/BRIEF.md
# UART interrupt and trigger controller

This block produces the single interrupt line of one UART channel. It keeps a four-bit sticky interrupt-source register and a four-bit mask register. The pending view is the source bits that are not masked, and the interrupt line is the OR of the pending bits. Software clears source bits by writing a clear pattern.

In FIFO mode the block compares the transmit and receive occupancy counts against thresholds. Each threshold is a three-bit level field scaled by a multiplier that depends on the channel. With the FIFO off, the receive-data-ready flag alone raises the receive source. The block also drives a level that tells a receive DMA engine the receive FIFO is empty. The FIFOs and the serial engine sit outside this block; they supply the counts, the flags and the one-cycle event pulses.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Source bit 0 is receive, bit 1 is error, bit 2 is transmit and bit 3 is modem. Bit 3 has no set condition in this block and stays 0. Once a source bit is set, it stays set until a clear write removes it.
- R2: `pendRd` equals `srcRd & ~maskRd`. `irq` is high exactly when `pendRd` is nonzero.
- R3: A write is `wrEn` high for one cycle, with `wrSel` choosing the target:
  - 0 selects FIFO control.
  - 1 selects control.
  - 2 selects mask.
  - 3 selects pending clear.
  - 4 selects source clear.
  - Selects 5 to 7 change nothing.

  Both clear writes remove the source bits that are 1 in `wrData[3:0]`. If a set condition for a bit is true in the same cycle as the clear, the set wins.
- R4: A mask write loads `wrData[3:0]`. The new mask appears on `maskRd`, `pendRd` and `irq` after the next rising clock edge.
- R5: In the FIFO-control word, `wrData[0]` enables FIFO mode, `wrData[6:4]` is the receive level and `wrData[10:8]` is the transmit level.
  - The transmit threshold is the transmit level times M.
  - The receive threshold is (receive level + 1) times M.
  - M is 32 for channel 0, 8 for channels 1 and 4, and 2 for channels 2 and 3. For any other channel both thresholds are 0.
- R6: With FIFO mode on, the transmit source is set in any cycle where `txCount` is less than or equal to the transmit threshold.
- R7: With FIFO mode on, the receive source is set when `rxCount` is at or above the receive threshold. It is also set when `rxCount` is nonzero and the timeout-enable bit is 0. The timeout-enable bit is bit 7 of the control word.
- R8: With FIFO mode off, the receive source is set whenever `rxReady` is high, and the transmit count sets nothing.
- R9: Bits 1:0 of the control word select the receive DMA mode.
  - When they equal 2, `dmaBusy` is high exactly while `rxCount` is 0.
  - For any other value of these bits, `dmaBusy` is low.
- R10: An `errEvent` pulse sets the error source. An `rxTimeout` pulse sets the receive source when `rxReady` is high.
- R11: After reset, all configuration, mask and source bits are 0, `irq` is low and `dmaBusy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Write target select |
| wrData | input | 11 | Write data |
| txCount | input | CNT_W | Transmit FIFO occupancy |
| rxCount | input | CNT_W | Receive FIFO occupancy |
| rxReady | input | 1 | Receive data ready flag |
| rxTimeout | input | 1 | Receive timeout event pulse |
| errEvent | input | 1 | Receive error event pulse |
| irq | output | 1 | Interrupt request level |
| dmaBusy | output | 1 | Receive DMA busy level |
| pendRd | output | 4 | Pending bits |
| srcRd | output | 4 | Source bits |
| maskRd | output | 4 | Mask bits |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as an active set condition, because the set must win. The bench brings it about by holding an error pulse during a full clear write. The next hardest is the receive threshold at its highest level, which the 8-bit count can never reach; the bench holds the count at its maximum with the timeout enable set, so only the threshold path could raise the bit. The bench also turns the timeout enable off with a single byte waiting, which exercises the any-data path of the receive source with a one-cycle delay in the configuration.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_W     = 4;
  localparam int SRC_RX    = 0;
  localparam int SRC_ERR   = 1;
  localparam int SRC_TX    = 2;
  localparam int SRC_MODEM = 3;

  localparam int WR_W  = 11;
  localparam int LVL_W = 3;

  // field positions inside the write word
  localparam int FC_EN_BIT  = 0;
  localparam int FC_RXLVL_LO = 4;
  localparam int FC_TXLVL_LO = 8;
  localparam int CT_TOEN_BIT = 7;
  localparam int CT_DMA_LO   = 0;

  typedef enum logic [2:0] {
    SEL_FIFO = 3'd0,
    SEL_CTL  = 3'd1,
    SEL_MASK = 3'd2,
    SEL_PCLR = 3'd3,
    SEL_SCLR = 3'd4
  } regSel_e;

  typedef struct packed {
    logic             fifoEn;
    logic [LVL_W-1:0] txLvl;
    logic [LVL_W-1:0] rxLvl;
    logic             toEn;
    logic [1:0]       dmaMode;
  } cfg_t;

  typedef struct packed {
    logic             wrFifo;
    logic             wrCtl;
    logic             wrMask;
    logic             clrSrc;
    logic [SRC_W-1:0] setSrc;
  } strobe_t;

  function automatic int chanMult(input int ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_ctrl_ctl.sv
module uart_irq_ctrl_ctl
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8
) (
  input  logic             wrEn,
  input  logic [2:0]       wrSel,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             rxReady,
  input  logic             rxTimeout,
  input  logic             errEvent,
  input  cfg_t             cfg,
  output strobe_t          stb,
  output logic             dmaBusy
);
  localparam int MULT  = chanMult(CHANNEL);
  localparam int THR_W = CNT_W + 6;

  logic [THR_W-1:0] txThr;
  logic [THR_W-1:0] rxThr;
  logic [THR_W-1:0] txCntW;
  logic [THR_W-1:0] rxCntW;
  logic             rxAny;

  assign txCntW = THR_W'(txCount);
  assign rxCntW = THR_W'(rxCount);
  assign rxAny  = (rxCount != '0);

  generate
    if (MULT == 0) begin : g_noMult
      assign txThr = '0;
      assign rxThr = '0;
    end else begin : g_mult
      assign txThr = THR_W'(cfg.txLvl) * THR_W'(MULT);
      assign rxThr = (THR_W'(cfg.rxLvl) + THR_W'(1)) * THR_W'(MULT);
    end
  endgenerate

  // register write decode
  always_comb begin
    stb.wrFifo = wrEn && (wrSel == SEL_FIFO);
    stb.wrCtl  = wrEn && (wrSel == SEL_CTL);
    stb.wrMask = wrEn && (wrSel == SEL_MASK);
    stb.clrSrc = wrEn && ((wrSel == SEL_PCLR) || (wrSel == SEL_SCLR));
  end

  // source set conditions
  always_comb begin
    stb.setSrc = '0;
    if (cfg.fifoEn) begin
      stb.setSrc[SRC_TX] = (txCntW <= txThr);
      stb.setSrc[SRC_RX] = (rxCntW >= rxThr) || (rxAny && !cfg.toEn);
    end else begin
      stb.setSrc[SRC_RX] = rxReady;
    end
    if (rxTimeout && rxReady) stb.setSrc[SRC_RX] = 1'b1;
    if (errEvent)             stb.setSrc[SRC_ERR] = 1'b1;
    stb.setSrc[SRC_MODEM] = 1'b0;
  end

  assign dmaBusy = (cfg.dmaMode == 2'b10) && !rxAny;
endmodule

// File: rtl/uart_irq_ctrl_dp.sv
module uart_irq_ctrl_dp
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic [WR_W-1:0]  wrData,
  output cfg_t             cfg,
  output logic [SRC_W-1:0] srcQ,
  output logic [SRC_W-1:0] maskQ,
  output logic [SRC_W-1:0] pend,
  output logic             irq
);
  logic [SRC_W-1:0] clrBits;
  logic [SRC_W-1:0] srcNext;

  assign clrBits = stb.clrSrc ? wrData[SRC_W-1:0] : '0;
  assign srcNext = (srcQ & ~clrBits) | stb.setSrc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      srcQ  <= '0;
      maskQ <= '0;
    end else begin
      if (stb.wrFifo) begin
        cfg.fifoEn <= wrData[FC_EN_BIT];
        cfg.txLvl  <= wrData[FC_TXLVL_LO +: LVL_W];
        cfg.rxLvl  <= wrData[FC_RXLVL_LO +: LVL_W];
      end
      if (stb.wrCtl) begin
        cfg.toEn    <= wrData[CT_TOEN_BIT];
        cfg.dmaMode <= wrData[CT_DMA_LO +: 2];
      end
      if (stb.wrMask) maskQ <= wrData[SRC_W-1:0];
      srcQ <= srcNext;
    end
  end

  assign pend = srcQ & ~maskQ;
  assign irq  = |pend;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [2:0]       wrSel,
  input  logic [WR_W-1:0]  wrData,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             rxReady,
  input  logic             rxTimeout,
  input  logic             errEvent,
  output logic             irq,
  output logic             dmaBusy,
  output logic [SRC_W-1:0] pendRd,
  output logic [SRC_W-1:0] srcRd,
  output logic [SRC_W-1:0] maskRd
);
  cfg_t    cfgQ;
  strobe_t stb;

  uart_irq_ctrl_ctl #(
    .CHANNEL(CHANNEL),
    .CNT_W  (CNT_W)
  ) u_ctl (
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .txCount  (txCount),
    .rxCount  (rxCount),
    .rxReady  (rxReady),
    .rxTimeout(rxTimeout),
    .errEvent (errEvent),
    .cfg      (cfgQ),
    .stb      (stb),
    .dmaBusy  (dmaBusy)
  );

  uart_irq_ctrl_dp u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (stb),
    .wrData(wrData),
    .cfg   (cfgQ),
    .srcQ  (srcRd),
    .maskQ (maskRd),
    .pend  (pendRd),
    .irq   (irq)
  );
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wrEn,
  input logic [2:0]       wrSel,
  input logic [WR_W-1:0]  wrData,
  input logic             errEvent,
  input logic [CNT_W-1:0] rxCount,
  input logic             dmaBusy,
  input logic [SRC_W-1:0] pendRd,
  input logic [SRC_W-1:0] srcRd,
  input logic [SRC_W-1:0] maskRd
);
  logic clrWrite;
  assign clrWrite = wrEn && ((wrSel == 3'd3) || (wrSel == 3'd4));

  // R1
  src_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clrWrite |=> ((srcRd & $past(srcRd)) == $past(srcRd)));

  // R2
  pend_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pendRd & maskRd) == '0) && ((pendRd & ~srcRd) == '0));

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && (wrSel == 3'd2)) |=> (maskRd == $past(wrData[SRC_W-1:0])));

  // R10
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errEvent |=> srcRd[SRC_ERR]);

  // R9
  dma_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmaBusy |-> (rxCount == '0));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .wrData  (wrData),
  .errEvent(errEvent),
  .rxCount (rxCount),
  .dmaBusy (dmaBusy),
  .pendRd  (pendRd),
  .srcRd   (srcRd),
  .maskRd  (maskRd)
);

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb;
  localparam int CH    = 0;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrSel = '0;
  logic [10:0] wrData = '0;
  logic [CNT_W-1:0] txCount = '0;
  logic [CNT_W-1:0] rxCount = '0;
  logic rxReady = 1'b0;
  logic rxTimeout = 1'b0;
  logic errEvent = 1'b0;
  logic irq, dmaBusy;
  logic [3:0] pendRd, srcRd, maskRd;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_irq_ctrl #(.CHANNEL(CH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .txCount(txCount), .rxCount(rxCount), .rxReady(rxReady),
    .rxTimeout(rxTimeout), .errEvent(errEvent), .irq(irq),
    .dmaBusy(dmaBusy), .pendRd(pendRd), .srcRd(srcRd), .maskRd(maskRd)
  );

  function automatic int scaleOf(input int ch);
    if (ch == 0) return 32;
    if (ch == 1 || ch == 4) return 8;
    if (ch == 2 || ch == 3) return 2;
    return 0;
  endfunction

  // behavioural reference state
  int mSrc = 0, mMask = 0, mEn = 0, mTxL = 0, mRxL = 0, mTo = 0, mDma = 0;

  always @(posedge clk) begin
    int setv, clrv;
    if (!rst_n) begin
      mSrc = 0; mMask = 0; mEn = 0; mTxL = 0; mRxL = 0; mTo = 0; mDma = 0;
    end else begin
      setv = 0;
      if (mEn != 0) begin
        if (int'(txCount) <= mTxL * scaleOf(CH)) setv |= 4;
        if (int'(rxCount) >= (mRxL + 1) * scaleOf(CH) || (rxCount != 0 && mTo == 0)) setv |= 1;
      end else if (rxReady) setv |= 1;
      if (rxTimeout && rxReady) setv |= 1;
      if (errEvent) setv |= 2;
      clrv = (wrEn && (wrSel == 3 || wrSel == 4)) ? int'(wrData) & 15 : 0;
      mSrc = ((mSrc & ~clrv) | setv) & 15;
      if (wrEn && wrSel == 0) begin
        mEn = int'(wrData[0]); mRxL = int'(wrData[6:4]); mTxL = int'(wrData[10:8]);
      end
      if (wrEn && wrSel == 1) begin
        mTo = int'(wrData[7]); mDma = int'(wrData[1:0]);
      end
      if (wrEn && wrSel == 2) mMask = int'(wrData[3:0]);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int ePend;
    if (!finished) begin
      ePend = mSrc & ~mMask & 15;
      chk("R1 srcRd", int'(srcRd), mSrc);
      chk("R2 pendRd", int'(pendRd), ePend);
      chk("R2 irq", int'(irq), (ePend != 0) ? 1 : 0);
      chk("R4 maskRd", int'(maskRd), mMask);
      chk("R9 dmaBusy", int'(dmaBusy), (mDma == 2 && rxCount == 0) ? 1 : 0);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wrEn = 1'b0; wrSel = '0; wrData = '0; rxTimeout = 1'b0; errEvent = 1'b0;
  endtask

  task automatic wr(input int sel, input int data);
    wrEn = 1'b1; wrSel = 3'(sel); wrData = 11'(data);
    tick();
    idle();
  endtask

  initial begin
    idle();
    repeat (3) tick();
    rst_n = 1'b1;
    #2;
    // R11 reset state
    chk("R11 irq", int'(irq), 0);
    chk("R11 srcRd", int'(srcRd), 0);
    chk("R11 dmaBusy", int'(dmaBusy), 0);
    chk("R11 maskRd", int'(maskRd), 0);

    // R8 FIFO off: data ready sets receive, empty tx count ignored
    rxReady = 1'b1; txCount = 0;
    tick(); #2;
    chk("R8 srcRd", int'(srcRd), 1);
    chk("R2 irq", int'(irq), 1);
    rxReady = 1'b0;
    wr(4, 1); #2;
    chk("R3 source clear", int'(srcRd), 0);

    // R4 / R2 masking
    wr(2, 1); #2;
    chk("R4 maskRd", int'(maskRd), 1);
    rxReady = 1'b1; tick(); rxReady = 1'b0; #2;
    chk("R2 masked pend", int'(pendRd), 0);
    chk("R2 masked irq", int'(irq), 0);
    chk("R1 src kept", int'(srcRd), 1);
    wr(2, 0); #2;
    chk("R4 unmask irq", int'(irq), 1);
    wr(3, 1); #2;
    chk("R3 pending clear", int'(srcRd), 0);

    // R3 invalid selects ignored
    wr(5, 11'h7ff); wr(6, 11'h002); wr(7, 11'h101);
    tick(); #2;
    chk("R3 ignored mask", int'(maskRd), 0);
    chk("R3 ignored ctl", int'(dmaBusy), 0);
    chk("R3 ignored fifo", int'(srcRd), 0);

    // FIFO mode, channel 0 multiplier 32
    txCount = 40; rxCount = 0;
    wr(1, 11'h080);
    wr(0, 11'h101);
    tick(); #2;
    chk("R6 above tx threshold", int'(srcRd), 0);
    txCount = 33; tick(); #2;
    chk("R6 tx 33", int'(srcRd), 0);
    txCount = 32; tick(); #2;
    chk("R6 tx at threshold", int'(srcRd), 4);
    txCount = 40; wr(4, 15); #2;
    chk("R3 clear tx", int'(srcRd), 0);
    rxCount = 31; tick(); #2;
    chk("R7 rx below threshold", int'(srcRd), 0);
    rxCount = 32; tick(); #2;
    chk("R5 rx threshold 32", int'(srcRd), 1);
    rxCount = 1; wr(4, 15); #2;
    chk("R7 timeout on, one byte", int'(srcRd), 0);
    wr(1, 11'h000); #2;
    chk("R7 config lag", int'(srcRd), 0);
    tick(); #2;
    chk("R7 any data timeout off", int'(srcRd), 1);
    rxCount = 0; wr(4, 15);

    // R5 top receive level unreachable
    wr(1, 11'h080);
    wr(0, 11'h171);
    rxCount = 255; tick(); tick(); #2;
    chk("R5 rx level 7", int'(srcRd), 0);
    rxCount = 0;
    wr(0, 11'h001);
    tick(); #2;
    chk("R5 tx level 0 count 40", int'(srcRd), 0);
    txCount = 0; tick(); #2;
    chk("R5 tx level 0 count 0", int'(srcRd), 4);
    txCount = 40; wr(4, 15);

    // R10 events
    errEvent = 1'b1; tick(); errEvent = 1'b0; #2;
    chk("R10 error", int'(srcRd), 2);
    errEvent = 1'b1; wrEn = 1'b1; wrSel = 3'd4; wrData = 11'h00f;
    tick(); idle(); #2;
    chk("R3 set wins", int'(srcRd), 2);
    wr(4, 15);
    rxTimeout = 1'b1; tick(); rxTimeout = 1'b0; #2;
    chk("R10 timeout no data", int'(srcRd), 0);
    rxReady = 1'b1; rxTimeout = 1'b1; tick(); rxTimeout = 1'b0; rxReady = 1'b0; #2;
    chk("R10 timeout with data", int'(srcRd), 1);
    chk("R1 modem bit", int'(srcRd[3]), 0);
    wr(4, 15);

    // R9 DMA busy
    wr(1, 11'h082); #2;
    chk("R9 busy empty", int'(dmaBusy), 1);
    rxCount = 5; #1;
    chk("R9 busy with data", int'(dmaBusy), 0);
    rxCount = 0; wr(1, 11'h081); #2;
    chk("R9 other mode", int'(dmaBusy), 0);

    repeat (4) tick();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule